// File: doc/BRIEF.md
# Word-Commanded SPI Master

This block drives an SPI bus as a master, one queued command word at a time. Each 32-bit command carries up to 16 data bits together with its own controls: which of four chip selects to drive, how many bits to shift, whether the transfer ends after this word, whether a frame boundary follows it, and whether the received bits are wanted at all. The command queue and the receive queue sit outside the block and are reached through valid/ready ports.

The engine runs in SPI mode 0. SCK idles low, MOSI changes after each falling edge and MISO is sampled on each rising edge. Bits go out MSB first within the programmed length. At a transfer or frame boundary the engine holds SCK low for a programmed number of SCK periods. It stalls new words that want their received data while the previous received word has not been taken. A message longer than 16 bits is sent as several words that keep the selects asserted until the last one.

Top module: `spi_word_master`

## Requirements
- R1: Command fields: bits 15:0 data, bits 19:16 select controls (bit 16+i controls `ssel_n[i]`), bit 20 end-of-transfer, bit 21 end-of-frame, bit 22 receive-ignore, bits 27:24 length code. A code c of 3 or more shifts c+1 bits, exactly that many SCK pulses.
- R2: Mode 0 timing: SCK is low whenever no word is shifting; each SCK half period lasts `clk_div`+1 clock cycles; MOSI presents data bits n-1 down to 0, MSB first, stable at each rising edge.
- R3: On acceptance `ssel_n[i]` takes command bit 16+i and stays unchanged while the word shifts.
- R4: With end-of-transfer set, `ssel_n` becomes 4'hF right after the last falling SCK edge of the word.
- R5: With end-of-transfer clear, `ssel_n` keeps the word's select value after the word ends.
- R6: When the next word is already waiting, SCK stays low between two words for `clk_div`+2+2·D·(`clk_div`+1) clock cycles, where D is the larger of (`xfer_dly` if end-of-transfer, else 0) and (`frame_dly` if end-of-frame, else 0).
- R7: With receive-ignore clear, the n received bits appear right-justified and zero-extended on `rx_data` with `rx_valid`. Both hold until `rx_ready`. No such word is accepted while `rx_valid` is high.
- R8: With receive-ignore set, no `rx_valid` is raised, `rx_data` is left unchanged, and the word is accepted even while `rx_valid` is high.
- R9: Length codes 0, 1 and 2 shift 4 bits and set `len_err`, which stays set until reset.
- R10: After reset, `sck` is 0, `ssel_n` is 4'hF, `rx_valid` is 0, `len_err` is 0 and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_div | input | DIV_W | SCK half period minus one, in clock cycles |
| xfer_dly | input | DLY_W | Delay after end-of-transfer, in SCK periods |
| frame_dly | input | DLY_W | Delay after end-of-frame, in SCK periods |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Command word accepted this cycle if valid |
| cmd_data | input | 32 | Command word |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Receive queue takes the word |
| rx_data | output | 16 | Received bits, right-justified |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ssel_n | output | 4 | Active-low chip selects |
| len_err | output | 1 | Sticky reserved-length flag |

## Verification
A wrong bit counter or a lost length shows at the ports within one word: the SCK pulse count or the captured MOSI pattern differs as soon as the word ends. A wrong delay counter or a wrong delay choice changes the SCK low gap before the very next word by whole half periods. A broken receive-ignore or backpressure path shows as a word that starts while the receive output is full, or as `rx_data` overwritten by an ignored word, before that receive word is read.

// File: rtl/spi_word_master.sv
module spi_word_master #(
  parameter int DIV_W = 8,
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [DLY_W-1:0] xfer_dly,
  input  logic [DLY_W-1:0] frame_dly,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [31:0]      cmd_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [15:0]      rx_data,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  output logic [3:0]       ssel_n,
  output logic             len_err
);
  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_DELAY} st_t;

  st_t              state;
  logic [DIV_W-1:0] cnt;
  logic             ph;
  logic [3:0]       bc;
  logic [15:0]      txsh, rxsh;
  logic             cur_eot, cur_eof, cur_ign;
  logic [DLY_W:0]   dcnt;

  wire [3:0]       code     = cmd_data[27:24];
  wire             reserved = code < 4'd3;
  wire [3:0]       lc       = reserved ? 4'd3 : code;
  wire             half_end = cnt == clk_div;
  wire             accept   = cmd_valid && cmd_ready;
  wire [DLY_W-1:0] dx       = cur_eot ? xfer_dly : '0;
  wire [DLY_W-1:0] df       = cur_eof ? frame_dly : '0;
  wire [DLY_W-1:0] dsel     = (dx > df) ? dx : df;

  assign cmd_ready = (state == S_IDLE) && (!rx_valid || cmd_data[22]);
  assign mosi      = txsh[15];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      ph       <= 1'b0;
      bc       <= '0;
      txsh     <= '0;
      rxsh     <= '0;
      cur_eot  <= 1'b0;
      cur_eof  <= 1'b0;
      cur_ign  <= 1'b0;
      dcnt     <= '0;
      sck      <= 1'b0;
      ssel_n   <= '1;
      rx_valid <= 1'b0;
      rx_data  <= '0;
      len_err  <= 1'b0;
    end else begin
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            state   <= S_SHIFT;
            cnt     <= '0;
            ph      <= 1'b0;
            bc      <= lc;
            txsh    <= cmd_data[15:0] << (4'd15 - lc);
            rxsh    <= '0;
            ssel_n  <= cmd_data[19:16];
            cur_eot <= cmd_data[20];
            cur_eof <= cmd_data[21];
            cur_ign <= cmd_data[22];
            if (reserved) len_err <= 1'b1;
          end
        end
        S_SHIFT: begin
          if (!half_end) begin
            cnt <= cnt + 1'b1;
          end else begin
            cnt <= '0;
            if (!ph) begin
              sck  <= 1'b1;
              ph   <= 1'b1;
              rxsh <= {rxsh[14:0], miso};
            end else begin
              sck <= 1'b0;
              ph  <= 1'b0;
              if (bc == 4'd0) begin
                if (!cur_ign) begin
                  rx_valid <= 1'b1;
                  rx_data  <= rxsh;
                end
                if (cur_eot) ssel_n <= '1;
                if (dsel != '0) begin
                  state <= S_DELAY;
                  dcnt  <= {dsel, 1'b0};
                end else begin
                  state <= S_IDLE;
                end
              end else begin
                bc   <= bc - 1'b1;
                txsh <= {txsh[14:0], 1'b0};
              end
            end
          end
        end
        default: begin
          if (!half_end) begin
            cnt <= cnt + 1'b1;
          end else begin
            cnt <= '0;
            if (dcnt == 1) state <= S_IDLE;
            else dcnt <= dcnt - 1'b1;
          end
        end
      endcase
    end
  end

  p_rx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid && $stable(rx_data));

  p_ssel_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SHIFT && $past(state) == S_SHIFT) |-> $stable(ssel_n));

  p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state != S_SHIFT |-> !sck);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |=> len_err);

  p_eot_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_SHIFT && $past(state) == S_SHIFT && $past(cur_eot)) |-> ssel_n == 4'hF);
endmodule

// File: tb/spi_word_master_tb.sv
`timescale 1ns/1ps
module spi_word_master_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  clk_div = 8'd0;
  logic [3:0]  xfer_dly = 4'd0, frame_dly = 4'd0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_data = 32'd0;
  logic        rx_valid, rx_ready = 1'b0;
  logic [15:0] rx_data;
  logic        sck, mosi, miso;
  logic [3:0]  ssel_n;
  logic        len_err;

  int nchk = 0, nfail = 0;
  bit timeout = 0;
  logic [31:0] cap = 0;
  int ncap = 0;
  int run = 0, last_gap = 0;

  always #2.5 clk = ~clk;
  assign miso = ~mosi;

  spi_word_master u_dut (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .xfer_dly(xfer_dly),
    .frame_dly(frame_dly), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .sck(sck), .mosi(mosi), .miso(miso),
    .ssel_n(ssel_n), .len_err(len_err));

  always @(posedge sck) begin
    cap  <= {cap[30:0], mosi};
    ncap <= ncap + 1;
  end

  always @(negedge clk) begin
    if (!sck) run <= run + 1;
    else begin
      if (run > 0) last_gap <= run;
      run <= 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic [31:0] mk(input [3:0] c, input [15:0] d, input [3:0] sel,
                               input bit eot, input bit eof, input bit ign);
    mk = {4'd0, c, 1'b0, ign, eof, eot, sel, d};
  endfunction

  task automatic send(input [31:0] c);
    cmd_data = c;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic take_rx();
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  task automatic wait_bits(input int base, input int n);
    while (ncap - base < n) @(negedge clk);
  endtask

  task automatic run_all();
    logic [15:0] pats [3];
    int c0, n;
    logic [31:0] m;
    logic [15:0] d, keep;
    pats[0] = 16'hA5C3; pats[1] = 16'h5A3C; pats[2] = 16'h8001;

    repeat (3) @(negedge clk);
    // R10 reset state
    check(sck == 1'b0, "R10 sck", sck, 0);
    check(ssel_n == 4'hF, "R10 ssel_n", ssel_n, 4'hF);
    check(rx_valid == 1'b0, "R10 rx_valid", rx_valid, 0);
    check(len_err == 1'b0, "R10 len_err", len_err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1'b1, "R10 cmd_ready", cmd_ready, 1);

    // R1 R2 R4 R7 R9: sweep of length codes, patterns and dividers
    for (int dv = 0; dv < 2; dv++) begin
      clk_div = (dv == 0) ? 8'd0 : 8'd2;
      for (int code = 3; code < 16; code++) begin
        for (int p = 0; p < 3; p++) begin
          n = code + 1;
          m = (32'd1 << n) - 1;
          d = pats[p] ^ (16'h1111 * code[3:0]);
          c0 = ncap;
          send(mk(code[3:0], d, ~(4'b0001 << (code % 4)), 1'b1, 1'b0, 1'b0));
          while (!rx_valid) @(negedge clk);
          check(ncap - c0 == n, "R1 bit count", ncap - c0, n);
          check((cap & m) == ({16'd0, d} & m), "R2 mosi bits", cap & m, {16'd0, d} & m);
          check({16'd0, rx_data} == ({16'd0, ~d} & m), "R7 rx_data", rx_data, {16'd0, ~d} & m);
          check(ssel_n == 4'hF, "R4 ssel release", ssel_n, 4'hF);
          take_rx();
        end
      end
    end
    check(len_err == 1'b0, "R9 no error on legal codes", len_err, 0);

    // R9 reserved codes
    for (int code = 0; code < 3; code++) begin
      c0 = ncap;
      send(mk(code[3:0], 16'h000B, 4'b1110, 1'b1, 1'b0, 1'b0));
      while (!rx_valid) @(negedge clk);
      check(ncap - c0 == 4, "R9 reserved length", ncap - c0, 4);
      check((cap & 32'hF) == 32'hB, "R9 reserved data", cap & 32'hF, 32'hB);
      check(len_err == 1'b1, "R9 len_err set", len_err, 1);
      take_rx();
    end

    // R5 select held without end-of-transfer, R3 select value
    clk_div = 8'd1;
    send(mk(4'd7, 16'h00C6, 4'b0101, 1'b0, 1'b0, 1'b0));
    check(ssel_n == 4'b0101, "R3 select at start", ssel_n, 4'b0101);
    while (!rx_valid) @(negedge clk);
    repeat (5) @(negedge clk);
    check(ssel_n == 4'b0101, "R5 select held", ssel_n, 4'b0101);
    take_rx();
    send(mk(4'd3, 16'h0009, 4'b0101, 1'b1, 1'b0, 1'b0));
    while (!rx_valid) @(negedge clk);
    check(ssel_n == 4'hF, "R4 release after chain", ssel_n, 4'hF);
    take_rx();

    // R6 gaps between ignore-words, R8 no rx_valid
    for (int k = 0; k < 6; k++) begin
      bit eot, eof;
      int xd, fd, dexp, gexp;
      case (k)
        0: begin eot = 0; eof = 0; xd = 5; fd = 7; end
        1: begin eot = 1; eof = 0; xd = 3; fd = 6; end
        2: begin eot = 0; eof = 1; xd = 3; fd = 6; end
        3: begin eot = 1; eof = 1; xd = 5; fd = 2; end
        4: begin eot = 1; eof = 1; xd = 2; fd = 4; end
        default: begin eot = 0; eof = 1; xd = 9; fd = 0; end
      endcase
      xfer_dly = xd[3:0]; frame_dly = fd[3:0];
      dexp = 0;
      if (eot && xd > dexp) dexp = xd;
      if (eof && fd > dexp) dexp = fd;
      gexp = 1 + 2 + 2 * dexp * 2;
      c0 = ncap;
      send(mk(4'd15, 16'hC35A, 4'b1110, eot, eof, 1'b1));
      send(mk(4'd7, 16'h0096, 4'b1110, 1'b1, 1'b0, 1'b1));
      wait_bits(c0, 17);
      @(negedge clk); @(negedge clk);
      check(last_gap == gexp, "R6 boundary gap", last_gap, gexp);
      wait_bits(c0, 24);
      repeat (12) @(negedge clk);
      check(cap[23:0] == 24'hC35A96, "R6 pair data", cap[23:0], 24'hC35A96);
      check(rx_valid == 1'b0, "R8 no rx_valid", rx_valid, 0);
    end
    xfer_dly = 4'd0; frame_dly = 4'd0;

    // R8 ignore word passes a full receive side; R7 backpressure
    send(mk(4'd7, 16'h003C, 4'b1110, 1'b1, 1'b0, 1'b0));
    while (!rx_valid) @(negedge clk);
    keep = rx_data;
    check(keep == 16'h00C3, "R7 first word", keep, 16'h00C3);
    c0 = ncap;
    send(mk(4'd11, 16'h0ABC, 4'b1101, 1'b1, 1'b0, 1'b1));
    wait_bits(c0, 12);
    repeat (10) @(negedge clk);
    check(rx_valid == 1'b1 && rx_data == keep, "R8 rx_data untouched", rx_data, keep);
    check((cap & 32'hFFF) == 32'hABC, "R8 ignore word sent", cap & 32'hFFF, 32'hABC);
    c0 = ncap;
    cmd_data = mk(4'd7, 16'h0055, 4'b1110, 1'b1, 1'b0, 1'b0);
    repeat (30) @(negedge clk);
    check(cmd_ready == 1'b0, "R7 stall ready", cmd_ready, 0);
    check(ncap == c0, "R7 stall no shift", ncap - c0, 0);
    take_rx();
    send(mk(4'd7, 16'h0055, 4'b1110, 1'b1, 1'b0, 1'b0));
    while (!rx_valid) @(negedge clk);
    check(rx_data == 16'h00AA, "R7 after release", rx_data, 16'h00AA);
    check(ncap - c0 == 8, "R7 after release count", ncap - c0, 8);
    take_rx();
    check(len_err == 1'b1, "R9 sticky", len_err, 1);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        timeout = 1;
      end
    join_any
    disable fork;
    if (timeout) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    end
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule